// File: doc/BRIEF.md
# Lane-Parallel Shift-and-Insert Unit

This block takes a source vector and a destination vector, shifts every lane of the source left or right by an immediate amount, and writes the shifted bits into the matching destination lane. Only the bit field that the shift fills is replaced. Every other destination bit is kept. The lane size and the shift amount both come from a two-part immediate: a 4-bit high field and a 3-bit low field. A width select chooses between a 128-bit vector and a 64-bit vector.

The unit has one register stage. A request presented with `in_valid` high produces its merged vector and two encoding flags on the next clock edge, and `out_valid` marks that cycle. Between requests the outputs hold their last values. An encoding that is illegal or reserved raises its flag, and the destination vector is then passed through unchanged, so a host can drop the result without any other handling.

The pipeline stage has two named states, each with an output process. IDLE means no result was produced on the last edge, and the unit goes to this state whenever `in_valid` is low at an edge. ISSUE means a result was produced on the last edge, and the unit goes to this state whenever `in_valid` is high.

Top module: `simd_shift_insert`

## Requirements
- R1: `decode_err` is 1 for a request whose `imm_hi` is 4'b0000, and 0 otherwise.
- R2: `reserved_err` is 1 for a request with `imm_hi[3]`=1 and `wide_mode`=0, and 0 otherwise.
- R3: The lane size E is 8 << p, where p is the index of the highest set bit of `imm_hi`. This gives E = 8, 16, 32 or 64. The concatenated immediate I = {imm_hi, imm_lo} is read as an unsigned 7-bit number.
- R4: Right insert (`dir_left`=0) uses s = 2E − I. In each lane, result bit j is source bit j+s when j < E−s, and destination bit j otherwise.
- R5: A right insert with s = E returns the destination lane unchanged.
- R6: Left insert (`dir_left`=1) uses s = I − E. In each lane, result bit j is source bit j−s when j ≥ s, and destination bit j otherwise.
- R7: A left insert with s = 0 returns the source lane in full.
- R8: When `wide_mode`=0 and neither flag is set, `result[127:64]` is zero and only the low 64 bits are processed.
- R9: When either flag is set, `result` equals the `dst_vec` of that request, all 128 bits.
- R10: `out_valid`, `result` and both flags are updated on the clock edge where `in_valid` is 1. `out_valid` is 1 in the following cycle only. The other outputs hold while `in_valid` is 0. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 128 | Source vector supplying the shifted bits |
| dst_vec | input | 128 | Destination vector supplying the kept bits |
| wide_mode | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| imm_hi | input | 4 | High immediate field (lane size and shift) |
| imm_lo | input | 3 | Low immediate field (shift) |
| dir_left | input | 1 | 1: left insert, 0: right insert |
| out_valid | output | 1 | Result produced on the last edge |
| result | output | 128 | Merged vector |
| decode_err | output | 1 | High immediate field was zero |
| reserved_err | output | 1 | 64-bit lanes requested in 64-bit mode |

## Verification
The bench aims at the shift extremes of every lane size.

- A full-width right insert must keep the destination. A design that builds its mask with a narrow shifter would wrap the shift and overwrite the lane.
- A zero left insert must take the whole source lane. An off-by-one lane-size decode would shift the wrong amount instead.
- In 64-bit mode the upper half must read as zero. A design that leaks the upper half would show destination bits there.
- An illegal encoding must pass the destination through. A design that merges anyway would corrupt it.

Random immediates at every lane size are also checked. These catch swapped shift formulas and lanes whose boundaries are misplaced.

// File: rtl/sis_pkg.sv
package sis_pkg;
    localparam int VEC_W    = 128;
    localparam int HALF_W   = VEC_W / 2;
    localparam int MIN_LANE = 8;
    localparam int NUM_SZ   = 4;
    localparam int SHW      = 8;

    typedef enum logic [1:0] {SZ_8, SZ_16, SZ_32, SZ_64} lane_sz_e;
    typedef enum logic {ST_IDLE, ST_ISSUE} pipe_st_e;

    function automatic lane_sz_e size_of(input logic [3:0] hi);
        if (hi[3])      return SZ_64;
        else if (hi[2]) return SZ_32;
        else if (hi[1]) return SZ_16;
        else            return SZ_8;
    endfunction
endpackage

// File: rtl/sis_decode.sv
module sis_decode
    import sis_pkg::*;
(
    input  logic [3:0]     imm_hi,
    input  logic [2:0]     imm_lo,
    input  logic           wide_mode,
    input  logic           dir_left,
    output lane_sz_e       lane_sz,
    output logic [SHW-1:0] shift_amt,
    output logic           dec_bad,
    output logic           rsv_bad
);
    logic [SHW-1:0] esize;
    logic [SHW-1:0] imm_full;

    always_comb begin
        lane_sz   = size_of(imm_hi);
        esize     = SHW'(MIN_LANE) << lane_sz;
        imm_full  = {1'b0, imm_hi, imm_lo};
        if (dir_left) shift_amt = imm_full - esize;
        else          shift_amt = (esize << 1) - imm_full;
        dec_bad   = (imm_hi == 4'b0000);
        rsv_bad   = imm_hi[3] && !wide_mode;
    end
endmodule

// File: rtl/sis_lane.sv
module sis_lane
    import sis_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   src,
    input  logic [W-1:0]   dst,
    input  logic [SHW-1:0] shift_amt,
    input  logic           dir_left,
    output logic [W-1:0]   merged
);
    logic [W-1:0] ones;
    logic [W-1:0] mask;
    logic [W-1:0] moved;

    always_comb begin
        ones = '1;
        if (dir_left) begin
            mask  = ones << shift_amt;
            moved = src << shift_amt;
        end else begin
            mask  = (shift_amt == SHW'(W)) ? '0 : (ones >> shift_amt);
            moved = src >> shift_amt;
        end
        merged = (dst & ~mask) | moved;
    end
endmodule

// File: rtl/simd_shift_insert.sv
module simd_shift_insert
    import sis_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   dst_vec,
    input  logic               wide_mode,
    input  logic [3:0]         imm_hi,
    input  logic [2:0]         imm_lo,
    input  logic               dir_left,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result,
    output logic               decode_err,
    output logic               reserved_err
);
    lane_sz_e       lane_sz;
    logic [SHW-1:0] shift_amt;
    logic           dec_bad;
    logic           rsv_bad;
    logic [VEC_W-1:0] merged_by_sz [NUM_SZ];
    logic [VEC_W-1:0] next_result;
    pipe_st_e       state_q;
    pipe_st_e       state_d;

    sis_decode u_dec (
        .imm_hi    (imm_hi),
        .imm_lo    (imm_lo),
        .wide_mode (wide_mode),
        .dir_left  (dir_left),
        .lane_sz   (lane_sz),
        .shift_amt (shift_amt),
        .dec_bad   (dec_bad),
        .rsv_bad   (rsv_bad)
    );

    for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
        localparam int LW = MIN_LANE << k;
        localparam int NL = VEC_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            sis_lane #(.W(LW)) u_lane (
                .src       (src_vec[l*LW +: LW]),
                .dst       (dst_vec[l*LW +: LW]),
                .shift_amt (shift_amt),
                .dir_left  (dir_left),
                .merged    (merged_by_sz[k][l*LW +: LW])
            );
        end
    end

    always_comb begin
        next_result = merged_by_sz[lane_sz];
        if (!wide_mode) next_result[VEC_W-1:HALF_W] = '0;
        if (dec_bad || rsv_bad) next_result = dst_vec;
        state_d = in_valid ? ST_ISSUE : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            decode_err   <= 1'b0;
            reserved_err <= 1'b0;
        end else if (in_valid) begin
            result       <= next_result;
            decode_err   <= dec_bad;
            reserved_err <= rsv_bad;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  out_valid = 1'b0;
            ST_ISSUE: out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sis_checker.sv
module sis_checker
    import sis_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] src_vec,
    input logic [VEC_W-1:0] dst_vec,
    input logic             wide_mode,
    input logic [3:0]       imm_hi,
    input logic [2:0]       imm_lo,
    input logic             dir_left,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             decode_err,
    input logic             reserved_err
);
    // R1
    decode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> decode_err == ($past(imm_hi) == 4'b0000));

    // R2
    reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> reserved_err == ($past(imm_hi[3]) && !$past(wide_mode)));

    // R5
    full_right_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_left && imm_hi == 4'b0001 && imm_lo == 3'b000 && wide_mode)
        |=> result == $past(dst_vec));

    // R7
    zero_left_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_left && imm_hi == 4'b0001 && imm_lo == 3'b000 && wide_mode)
        |=> result == $past(src_vec));

    // R8
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && imm_hi != 4'b0000 && !imm_hi[3])
        |=> result[VEC_W-1:HALF_W] == '0);

    // R9
    error_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (imm_hi == 4'b0000 || (imm_hi[3] && !wide_mode)))
        |=> result == $past(dst_vec));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(decode_err) && $stable(reserved_err));
endmodule

bind simd_shift_insert sis_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src_vec      (src_vec),
    .dst_vec      (dst_vec),
    .wide_mode    (wide_mode),
    .imm_hi       (imm_hi),
    .imm_lo       (imm_lo),
    .dir_left     (dir_left),
    .out_valid    (out_valid),
    .result       (result),
    .decode_err   (decode_err),
    .reserved_err (reserved_err)
);

// File: tb/simd_shift_insert_test.sv
module simd_shift_insert_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_vec = '0;
    logic [127:0] dst_vec = '0;
    logic         wide_mode = 1'b0;
    logic [3:0]   imm_hi = '0;
    logic [2:0]   imm_lo = '0;
    logic         dir_left = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         decode_err;
    logic         reserved_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [127:0] exp_res = '0;
    logic         exp_de = 1'b0;
    logic         exp_re = 1'b0;

    always #5 clk = ~clk;

    simd_shift_insert uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_vec(src_vec), .dst_vec(dst_vec), .wide_mode(wide_mode),
        .imm_hi(imm_hi), .imm_lo(imm_lo), .dir_left(dir_left),
        .out_valid(out_valid), .result(result),
        .decode_err(decode_err), .reserved_err(reserved_err)
    );

    // Bit-by-bit reference for R1..R9
    task automatic model(input logic [127:0] s, input logic [127:0] d, input logic q,
                         input logic [3:0] hi, input logic [2:0] lo, input logic left);
        int e;
        int imm;
        int sh;
        int width;
        exp_de = (hi == 4'd0);
        exp_re = hi[3] && !q;
        if (exp_de || exp_re) begin
            exp_res = d;
            return;
        end
        e = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
        imm = {hi, lo};
        sh = left ? imm - e : 2 * e - imm;
        width = q ? 128 : 64;
        exp_res = '0;
        for (int base = 0; base < width; base += e) begin
            for (int j = 0; j < e; j++) begin
                if (left) exp_res[base+j] = (j >= sh) ? s[base+j-sh] : d[base+j];
                else      exp_res[base+j] = (j < e - sh) ? s[base+j+sh] : d[base+j];
            end
        end
    endtask

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [127:0] s, input logic [127:0] d,
                       input logic q, input logic [3:0] hi, input logic [2:0] lo, input logic left);
        src_vec = s; dst_vec = d; wide_mode = q; imm_hi = hi; imm_lo = lo; dir_left = left;
        in_valid = 1'b1;
        model(s, d, q, hi, lo, left);
        @(negedge clk);
        check({req, " result"}, result, exp_res);
        check({req, " decode_err R1"}, {127'd0, decode_err}, {127'd0, exp_de});
        check({req, " reserved_err R2"}, {127'd0, reserved_err}, {127'd0, exp_re});
        check("R10 out_valid", {127'd0, out_valid}, 128'd1);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] a;
        logic [127:0] b;
        a = 128'h0123456789abcdef_fedcba9876543210;
        b = 128'h55aa33cc0ff0f00f_a5a5c3c39669e11e;
        @(negedge clk);
        check("R10 reset result", result, '0);
        check("R10 reset out_valid", {127'd0, out_valid}, '0);
        check("R10 reset flags", {126'd0, decode_err, reserved_err}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        run("R5 full right 8", a, b, 1'b1, 4'b0001, 3'b000, 1'b0);
        check("R5 keep dst", result, b);
        run("R5 full right 64", a, b, 1'b1, 4'b1000, 3'b000, 1'b0);
        check("R5 keep dst 64", result, b);
        run("R7 zero left 16", a, b, 1'b1, 4'b0010, 3'b000, 1'b0 ^ 1'b1);
        check("R7 take src", result, a);
        run("R4 right 1 in 32", a, b, 1'b1, 4'b0111, 3'b111, 1'b0);
        run("R6 left max in 64", a, b, 1'b1, 4'b1111, 3'b111, 1'b1);
        run("R3 size 16 right", a, b, 1'b1, 4'b0011, 3'b010, 1'b0);
        run("R8 narrow left", a, b, 1'b0, 4'b0101, 3'b001, 1'b1);
        check("R8 upper zero", {64'd0, result[127:64]}, '0);
        run("R1 zero hi", a, b, 1'b1, 4'b0000, 3'b101, 1'b1);
        check("R9 dst pass on decode", result, b);
        run("R2 reserved", a, b, 1'b0, 4'b1010, 3'b011, 1'b0);
        check("R9 dst pass on reserved", result, b);
        run("R2 not reserved wide", a, b, 1'b1, 4'b1010, 3'b011, 1'b0);

        in_valid = 1'b0;
        src_vec = '1; dst_vec = '0; imm_hi = 4'b0000;
        @(negedge clk);
        check("R10 hold result", result, exp_res);
        check("R10 idle out_valid", {127'd0, out_valid}, '0);
        check("R10 hold flags", {126'd0, decode_err, reserved_err}, {126'd0, exp_de, exp_re});

        for (int n = 0; n < 400; n++) begin
            logic [3:0] hi;
            hi = 4'($urandom);
            run("R4 R6 random", rnd128(), rnd128(), 1'($urandom), hi, 3'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule